// File: doc/BRIEF.md
# GPIO Bank with Masked-Write Register File

This block holds one bank of general-purpose pins: four ports of eight pins, 32 pins in all. A simple 32-bit register bus reaches every port. Each port has three writable registers and one read-only register. The writable ones are a mode register (GPIO or alternate function), a drive-enable register and an output-level register. The read-only register shows the synchronised pin levels. The block drives the pad output and output-enable lines, and it takes the pad inputs through a two-flop synchroniser.

Each writable register also has a masked alias. Through the alias, one bus write changes any subset of a port's pins and leaves the other pins alone, so software needs no read-modify-write sequence. A pin whose mode bit is clear is handed to the alternate-function logic, which then drives that pad directly.

The bus is single-cycle. A write takes effect on the clock edge where `bus_en_i` and `bus_we_i` are both high. Read data is combinational from `bus_addr_i`.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every mode, drive-enable and output-level register reads zero. Every pad therefore passes `alt_out_i` and `alt_oe_i` through.
- R2: Register addresses are formed as group*0x10 + port*4. The groups are mode 0, drive-enable 1, output-level 2 and input 3. Bits [1:0] and [10:6] of the address are zero.
- R3: A plain write (address bit 11 clear) replaces all eight bits of the addressed register with wdata[7:0]. Bits [31:8] of every read are zero.
- R4: A write to a writable register with address bit 11 set (the masked alias, at +0x800) changes pin n to wdata[n] only where wdata[8+n] is 1. All other pins keep their value.
- R5: The input group is read-only. Plain and masked writes to it have no effect.
- R6: When a pin's mode bit is 1, its pad output equals its output-level bit and its pad enable equals its drive-enable bit.
- R7: When a pin's mode bit is 0, its pad output and pad enable equal `alt_out_i` and `alt_oe_i` for that pin.
- R8: A pad input level shows in the input register two clock edges after it is applied. It does not show after only one edge.
- R9: A write with a nonzero address bit [1:0] or [10:6] changes no register. Such a read returns zero. A read of any masked-alias address also returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | 12 | Byte offset within the bank |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| alt_out_i | input | 32 | Alternate-function output values |
| alt_oe_i | input | 32 | Alternate-function output enables |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |

## Verification
The bench targets the masked alias with masks that are empty, partial and full. A design that ignored the mask byte, or took the value from the wrong byte, would clobber neighbouring pins. It writes the input group through both aliases and writes to addresses with stray offset bits set. A decoder that compared too few bits would then corrupt a live register. It samples the input register after one edge and again after two, which catches a synchroniser with the wrong number of stages. It also drives mode bits that differ from pin to pin, so that a pad multiplexer with swapped select polarity shows at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int ALIAS_BIT = 11;
  localparam int GRP_LSB   = 4;
  localparam int PORT_LSB  = 2;
  localparam int MASK_LSB  = 8;

  typedef enum logic [1:0] {
    GRP_MODE = 2'd0,
    GRP_DRV  = 2'd1,
    GRP_LVL  = 2'd2,
    GRP_IN   = 2'd3
  } grp_e;

  function automatic logic [7:0] merge_bits(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              alias_o,
  output grp_e              grp_o,
  output logic [1:0]        port_o
);
  // legal offsets: only alias, group and port fields may be nonzero
  assign hit_o   = (addr_i[ALIAS_BIT-1:GRP_LSB+2] == '0) && (addr_i[PORT_LSB-1:0] == '0);
  assign alias_o = addr_i[ALIAS_BIT];
  assign grp_o   = grp_e'(addr_i[GRP_LSB +: 2]);
  assign port_o  = addr_i[PORT_LSB +: 2];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mode_i,
  input  logic              wr_drv_i,
  input  logic              wr_lvl_i,
  input  logic [PORT_W-1:0] sel_i,
  input  logic [PORT_W-1:0] val_i,
  output logic [PORT_W-1:0] mode_o,
  output logic [PORT_W-1:0] drv_o,
  output logic [PORT_W-1:0] lvl_o
);
  logic [7:0] sel8, val8, mode8, drv8, lvl8;

  assign sel8 = 8'(sel_i);
  assign val8 = 8'(val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode8 <= '0;
      drv8  <= '0;
      lvl8  <= '0;
    end else begin
      if (wr_mode_i) mode8 <= merge_bits(mode8, val8, sel8);
      if (wr_drv_i)  drv8  <= merge_bits(drv8,  val8, sel8);
      if (wr_lvl_i)  lvl8  <= merge_bits(lvl8,  val8, sel8);
    end
  end

  assign mode_o = mode8[PORT_W-1:0];
  assign drv_o  = drv8[PORT_W-1:0];
  assign lvl_o  = lvl8[PORT_W-1:0];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_en_i,
  input  logic                        bus_we_i,
  input  logic [11:0]                 bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in_i,
  input  logic [NUM_PORTS*PORT_W-1:0] alt_out_i,
  input  logic [NUM_PORTS*PORT_W-1:0] alt_oe_i,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out_o,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe_o
);
  localparam int PINS = NUM_PORTS * PORT_W;

  logic        hit, is_alias;
  grp_e        grp;
  logic [1:0]  port;
  logic [PORT_W-1:0] wr_sel, wr_val;
  logic [PINS-1:0]   mode_q, drv_q, lvl_q, in_q;
  logic        unused_wdata;

  assign unused_wdata = ^bus_wdata_i[31:MASK_LSB+PORT_W];

  gpio_addr_dec u_dec (
    .addr_i  (bus_addr_i),
    .hit_o   (hit),
    .alias_o (is_alias),
    .grp_o   (grp),
    .port_o  (port)
  );

  assign wr_val = bus_wdata_i[0 +: PORT_W];
  assign wr_sel = is_alias ? bus_wdata_i[MASK_LSB +: PORT_W] : '1;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = bus_en_i && bus_we_i && hit && (port == 2'(p));

    gpio_port_regs #(.PORT_W(PORT_W)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_mode_i (port_wr && grp == GRP_MODE),
      .wr_drv_i  (port_wr && grp == GRP_DRV),
      .wr_lvl_i  (port_wr && grp == GRP_LVL),
      .sel_i     (wr_sel),
      .val_i     (wr_val),
      .mode_o    (mode_q[p*PORT_W +: PORT_W]),
      .drv_o     (drv_q[p*PORT_W +: PORT_W]),
      .lvl_o     (lvl_q[p*PORT_W +: PORT_W])
    );
  end

  gpio_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (in_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit && !is_alias) begin
      unique case (grp)
        GRP_MODE: bus_rdata_o[PORT_W-1:0] = mode_q[port*PORT_W +: PORT_W];
        GRP_DRV:  bus_rdata_o[PORT_W-1:0] = drv_q[port*PORT_W +: PORT_W];
        GRP_LVL:  bus_rdata_o[PORT_W-1:0] = lvl_q[port*PORT_W +: PORT_W];
        default:  bus_rdata_o[PORT_W-1:0] = in_q[port*PORT_W +: PORT_W];
      endcase
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pad
    assign pad_out_o[i] = mode_q[i] ? lvl_q[i] : alt_out_i[i];
    assign pad_oe_o[i]  = mode_q[i] ? drv_q[i] : alt_oe_i[i];
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_en_i,
  input logic        bus_we_i,
  input logic [11:0] bus_addr_i,
  input logic [31:0] bus_wdata_i,
  input logic [31:0] bus_rdata_o,
  input logic [31:0] pad_in_i,
  input logic [31:0] mode_q,
  input logic [31:0] drv_q,
  input logic [31:0] lvl_q,
  input logic [31:0] in_q
);
  logic [1:0]  cyc;
  logic        wr, legal, to_lvl;
  logic [31:0] keep_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assign wr        = bus_en_i && bus_we_i;
  assign legal     = (bus_addr_i[10:6] == 5'd0) && (bus_addr_i[1:0] == 2'd0);
  assign to_lvl    = legal && bus_addr_i[5:4] == 2'd2;
  assign keep_mask = ~({24'd0, bus_wdata_i[15:8]} << (8 * bus_addr_i[3:2]));

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc == 2'd0) |-> (mode_q == '0 && drv_q == '0 && lvl_q == '0)); // R1

  AST_PLAIN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && to_lvl && !bus_addr_i[11]) |=>
      lvl_q[8*$past(bus_addr_i[3:2]) +: 8] == $past(bus_wdata_i[7:0])); // R3

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[31:8] == 24'd0); // R3

  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && to_lvl && bus_addr_i[11]) |=>
      ((lvl_q ^ $past(lvl_q)) & $past(keep_mask)) == 32'd0); // R4

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !legal) |=> ($stable(mode_q) && $stable(drv_q) && $stable(lvl_q))); // R9

  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> in_q == $past(pad_in_i, 2)); // R8
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pad_in_i    (pad_in_i),
  .mode_q      (mode_q),
  .drv_q       (drv_q),
  .lvl_q       (lvl_q),
  .in_q        (in_q)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pad_in = '0, alt_out = '0, alt_oe = '0, pad_out, pad_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_mode [4], m_drv [4], m_lvl [4];

  always #4 clk = ~clk;

  gpio_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .alt_out_i(alt_out), .alt_oe_i(alt_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ra(input int grp, input int port, input bit msk);
    return (msk ? 12'h800 : 12'h000) | 12'(grp * 16) | 12'(port * 4);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic check_all_regs(input string tag);
    logic [31:0] d;
    for (int p = 0; p < 4; p++) begin
      rd(ra(0, p, 0), d); check(d == {24'd0, m_mode[p]}, tag, d, {24'd0, m_mode[p]});
      rd(ra(1, p, 0), d); check(d == {24'd0, m_drv[p]},  tag, d, {24'd0, m_drv[p]});
      rd(ra(2, p, 0), d); check(d == {24'd0, m_lvl[p]},  tag, d, {24'd0, m_lvl[p]});
    end
  endtask

  task automatic check_pads(input string tag);
    logic [31:0] eo, ee;
    #1;
    for (int i = 0; i < 32; i++) begin
      eo[i] = m_mode[i/8][i%8] ? m_lvl[i/8][i%8] : alt_out[i];
      ee[i] = m_mode[i/8][i%8] ? m_drv[i/8][i%8] : alt_oe[i];
    end
    check(pad_out == eo, {tag, " pad_out"}, pad_out, eo);
    check(pad_oe == ee,  {tag, " pad_oe"},  pad_oe,  ee);
  endtask

  task automatic t_reset;
    alt_out = 32'hA5C3_0F96; alt_oe = 32'h5A3C_F069;
    check_all_regs("R1 reset regs");
    check_pads("R1 reset pads");
  endtask

  task automatic t_plain;
    for (int p = 0; p < 4; p++) begin
      m_drv[p] = 8'h11 * 8'(p + 1);
      m_lvl[p] = 8'h3C ^ 8'(p * 37);
      wr(ra(1, p, 0), 32'hFFFF_FF00 | m_drv[p]);
      wr(ra(2, p, 0), 32'hDEAD_BE00 | m_lvl[p]);
    end
    check_all_regs("R2 R3 plain write map");
    wr(ra(2, 3, 0), 32'h0000_FF00);
    m_lvl[3] = 8'h00;
    check_all_regs("R3 full replace");
  endtask

  task automatic t_masked;
    wr(ra(2, 1, 0), 32'h0000_00A5); m_lvl[1] = 8'hA5;
    wr(ra(2, 1, 1), 32'h0000_0FF0); m_lvl[1] = 8'hA0;
    check_all_regs("R4 masked partial");
    wr(ra(2, 1, 1), 32'h0000_00FF);
    check_all_regs("R4 empty mask");
    wr(ra(1, 2, 1), 32'h0000_FF5A); m_drv[2] = 8'h5A;
    wr(ra(0, 0, 1), 32'h0000_8181); m_mode[0] = 8'h81;
    check_all_regs("R4 full and edge masks");
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pad_in = 32'h1234_5678;
    @(negedge clk); addr = ra(3, 1, 0); #1 d = rdata;
    check(d == 32'h0000_0000, "R8 one edge not visible", d, 32'h0);
    @(negedge clk); addr = ra(3, 1, 0); #1 d = rdata;
    check(d == 32'h0000_0056, "R8 two edges visible", d, 32'h56);
    wr(ra(3, 1, 0), 32'h0000_00FF);
    wr(ra(3, 2, 1), 32'h0000_FFFF);
    for (int p = 0; p < 4; p++) begin
      rd(ra(3, p, 0), d);
      check(d == {24'd0, 8'(32'h1234_5678 >> (8 * p))}, "R5 input unchanged", d,
            {24'd0, 8'(32'h1234_5678 >> (8 * p))});
    end
    check_all_regs("R5 write to input group no side effect");
  endtask

  task automatic t_pads;
    wr(ra(0, 2, 0), 32'h0000_00F0); m_mode[2] = 8'hF0;
    wr(ra(0, 3, 0), 32'h0000_00FF); m_mode[3] = 8'hFF;
    check_pads("R6 R7 mixed mode");
    alt_out = ~alt_out; alt_oe = ~alt_oe;
    check_pads("R7 alt passthrough follows");
    wr(ra(2, 3, 1), 32'h0000_0F0F); m_lvl[3] = (m_lvl[3] & 8'hF0) | 8'h0F;
    check_pads("R6 gpio level drives pad");
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h042, 32'h0000_FFFF);
    wr(12'h064, 32'h0000_FFFF);
    wr(12'h821, 32'h0000_FFFF);
    check_all_regs("R9 bad address write ignored");
    rd(12'h044, d); check(d == 0, "R9 bad address read zero", d, 0);
    rd(ra(1, 2, 1), d); check(d == 0, "R9 alias read zero", d, 0);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin m_mode[p] = 0; m_drv[p] = 0; m_lvl[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_masked();
    t_input();
    t_pads();
    t_unmapped();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule